// File: doc/BRIEF.md
# Serial SRAM SPI Master

This block is an SPI master for a serial SRAM. A client issues one request with an operation, a start address and a byte count. The block then runs the whole transaction on the serial pins. It lowers chip select, sends the command byte and the address bytes, and moves the data bytes. Write data is pulled from the client one byte at a time through a ready/valid handshake. Read data is returned one byte at a time with a single-cycle valid strobe.

Four operations are supported: data read, data write, mode-register read and mode-register write. The mode register selects how the memory treats a long transfer, either one byte per command or a sequential burst. The master always frames a burst as one command followed by as many data bytes as requested.

The address is two bytes long for memories of up to 512 Kbit and three bytes long for larger ones. A capacity parameter selects the length. The serial clock runs at a fixed division of the system clock.

Top module: `sram_spi_master`

## Requirements
- R1: A read request (op code 0) sends command byte 0x03, then the address, then `req_len` bytes of 0x00. It presents each byte captured on `spi_miso` on `rx_data` with a one-cycle `rx_valid` pulse, in transfer order.
- R2: A write request (op code 1) sends command byte 0x02, then the address, then `req_len` data bytes. Each data byte is taken from `tx_data` in a cycle where `tx_ready` and `tx_valid` are both high.
- R3: The address is `req_addr[15:0]` in two bytes when `MEM_KBIT` is 512 or less. It is `req_addr[23:0]` in three bytes when `MEM_KBIT` is larger. In both cases the most significant byte goes out first.
- R4: `spi_cs_n` falls once per transaction, before the first serial clock edge. It stays low through the command, the address and every data byte, and rises only after the last byte.
- R5: A mode-register read (op code 2) sends 0x05 and returns exactly one byte on `rx_data`. A mode-register write (op code 3) sends 0x01 followed by exactly one byte from the transmit handshake. For both, `req_len` has no effect.
- R6: The link uses SPI mode 0. `spi_sclk` idles low and is never high while `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. Bits travel most significant bit first.
- R7: `busy` rises on the clock edge that accepts a request and stays high until chip select has been released and the gap of R8 has elapsed. A request raised while `busy` is high is ignored and starts no transaction.
- R8: Between two transactions `spi_cs_n` stays high for at least `CS_GAP` (default 2) system clocks.
- R9: While a write byte is awaited (`tx_ready` high, `tx_valid` low), `spi_sclk` stays low and `spi_cs_n` stays low. The transfer resumes when the byte arrives.
- R10: A read or write with `req_len` = 0 sends only the command and the address bytes, then ends.
- R11: After reset, `spi_cs_n` is 1 and `spi_sclk`, `busy`, `tx_ready` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_op | input | 2 | 0 read, 1 write, 2 mode-register read, 3 mode-register write |
| req_addr | input | 24 | Start address (low two bytes used for small devices) |
| req_len | input | LEN_W | Number of data bytes for read and write |
| tx_valid | input | 1 | Write byte is present on `tx_data` |
| tx_data | input | 8 | Write byte |
| tx_ready | output | 1 | Master waits for the next write byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
Suppose the byte-phase sequencer holds a wrong phase or a wrong address-byte index. The command or address bytes seen by the memory model would then be wrong or miscounted, and this shows at the end of the very transaction. Suppose instead the remaining-byte count or the in-flight flag is corrupted. Then chip select rises early or late, or a strobe or handshake is missing, and the per-transaction byte count exposes this after at most one byte time. A fault in the bit shifter would break the clock and data phasing, which is caught at the next serial clock edge, or it would give a wrong captured byte at the next `rx_valid`.

// File: rtl/sram_spi_pkg.sv
// Shared types for the serial SRAM master: request operations, command
// bytes and the sequencer phases. Assumes one chip select per master.
package sram_spi_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RDMODE = 2'd2,
        OP_WRMODE = 2'd3
    } sram_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam logic [7:0] CMD_BYTE_READ   = 8'h03;
    localparam logic [7:0] CMD_BYTE_WRITE  = 8'h02;
    localparam logic [7:0] CMD_BYTE_RDMODE = 8'h05;
    localparam logic [7:0] CMD_BYTE_WRMODE = 8'h01;

    // Command byte that goes on the wire for an operation.
    function automatic logic [7:0] cmd_byte(input sram_op_e op);
        case (op)
            OP_READ:   return CMD_BYTE_READ;
            OP_WRITE:  return CMD_BYTE_WRITE;
            OP_RDMODE: return CMD_BYTE_RDMODE;
            default:   return CMD_BYTE_WRMODE;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
// One-byte SPI mode-0 shifter. A start pulse loads a byte and puts its MSB
// on MOSI while SCLK is low. Each SCLK half period is HALF_DIV system
// clocks. MISO is sampled on rising SCLK and MOSI advances on falling
// SCLK. Done pulses for one cycle after the eighth falling edge, with
// SCLK low again. Assumes start is raised only while the shifter is idle.
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] dout
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic          active;
    logic [CW-1:0] div_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    // Divide the clock, toggle SCLK and shift both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                tx_sh   <= din;
                div_cnt <= '0;
                bit_idx <= '0;
                sclk    <= 1'b0;
            end else if (active) begin
                if (div_cnt == CNT_LAST) begin
                    div_cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + CW'(1);
                end
            end
        end
    end

    // MSB of the transmit register drives the line.
    always_comb mosi = tx_sh[7];
    // Captured byte is complete when done pulses.
    always_comb dout = rx_sh;

endmodule

// File: rtl/sram_frame_ctrl.sv
// Transaction sequencer for the serial SRAM master. It accepts a request
// while idle, lowers chip select, and walks through the command, address
// and data phases, starting the byte shifter once per byte. It then holds
// chip select high for CS_GAP cycles. Assumes a shifter that answers each
// start with exactly one done pulse.
module sram_frame_ctrl
    import sram_spi_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int LEN_W      = 16,
    parameter int CS_GAP     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_din,
    input  logic             sh_done,
    input  logic [7:0]       sh_dout
);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);
    localparam logic [1:0]    IDX_LAST = 2'(ADDR_BYTES - 1);

    phase_e           phase;
    sram_op_e         op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] remain;
    logic [1:0]       addr_idx;
    logic             in_flight;
    logic [GW-1:0]    gap_cnt;
    logic             op_writes;
    logic             op_mode;
    logic [4:0]       addr_shamt;

    // Decode the latched operation.
    always_comb begin
        op_writes = (op_q == OP_WRITE) || (op_q == OP_WRMODE);
        op_mode   = (op_q == OP_RDMODE) || (op_q == OP_WRMODE);
    end

    // Handshake and shifter launch for the current phase.
    always_comb begin
        tx_ready = (phase == PH_DATA) && op_writes && !in_flight;
        sh_start = !in_flight &&
                   ((phase == PH_CMD) || (phase == PH_ADDR) ||
                    ((phase == PH_DATA) && (!op_writes || tx_valid)));
    end

    // Pick the byte to send: command, address byte (MSB first) or data.
    always_comb begin
        addr_shamt = {IDX_LAST - addr_idx, 3'b000};
        case (phase)
            PH_CMD:  sh_din = cmd_byte(op_q);
            PH_ADDR: sh_din = 8'(addr_q >> addr_shamt);
            PH_DATA: sh_din = op_writes ? tx_data : 8'h00;
            default: sh_din = 8'h00;
        endcase
    end

    // Busy spans the whole transaction including the chip-select gap.
    always_comb busy = (phase != PH_IDLE);

    // Phase sequencing, byte counting and received-byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            op_q      <= OP_READ;
            addr_q    <= '0;
            remain    <= '0;
            addr_idx  <= '0;
            in_flight <= 1'b0;
            gap_cnt   <= '0;
            cs_n      <= 1'b1;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sh_start) begin
                in_flight <= 1'b1;
            end
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        op_q     <= sram_op_e'(req_op);
                        addr_q   <= req_addr;
                        addr_idx <= '0;
                        cs_n     <= 1'b0;
                        phase    <= PH_CMD;
                        if (req_op[1]) begin
                            remain <= LEN_W'(1);
                        end else begin
                            remain <= req_len;
                        end
                    end
                end
                PH_CMD: begin
                    if (sh_done) begin
                        in_flight <= 1'b0;
                        phase     <= op_mode ? PH_DATA : PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (sh_done) begin
                        in_flight <= 1'b0;
                        if (addr_idx == IDX_LAST) begin
                            if (remain == '0) begin
                                phase   <= PH_GAP;
                                cs_n    <= 1'b1;
                                gap_cnt <= '0;
                            end else begin
                                phase <= PH_DATA;
                            end
                        end else begin
                            addr_idx <= addr_idx + 2'd1;
                        end
                    end
                end
                PH_DATA: begin
                    if (sh_done) begin
                        in_flight <= 1'b0;
                        if (!op_writes) begin
                            rx_valid <= 1'b1;
                            rx_data  <= sh_dout;
                        end
                        if (remain == LEN_W'(1)) begin
                            phase   <= PH_GAP;
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                        end
                        remain <= remain - LEN_W'(1);
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        phase <= PH_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_spi_master.sv
// Top of the serial SRAM SPI master. It derives the address length from
// the device capacity and joins the transaction sequencer to the mode-0
// byte shifter. Assumes one memory on the bus and a fixed SCLK division.
module sram_spi_master #(
    parameter int MEM_KBIT = 256,
    parameter int SCK_HALF = 2,
    parameter int LEN_W    = 16,
    parameter int CS_GAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int ADDR_BYTES = (MEM_KBIT > 512) ? 3 : 2;

    logic       sh_start;
    logic [7:0] sh_din;
    logic       sh_done;
    logic [7:0] sh_dout;

    sram_frame_ctrl #(
        .ADDR_BYTES (ADDR_BYTES),
        .LEN_W      (LEN_W),
        .CS_GAP     (CS_GAP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .busy      (busy),
        .cs_n      (spi_cs_n),
        .sh_start  (sh_start),
        .sh_din    (sh_din),
        .sh_done   (sh_done),
        .sh_dout   (sh_dout)
    );

    spi_byte_shifter #(
        .HALF_DIV (SCK_HALF)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .din   (sh_din),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .dout  (sh_dout)
    );

endmodule

// File: rtl/sram_spi_master_chk.sv
// Protocol checker for the serial SRAM master, bound to every instance.
// Assumes the synchronous active-low reset of the design.
module sram_spi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic busy,
    input logic tx_ready,
    input logic rx_valid
);
    // Serial clock only pulses inside a selected transaction.
    p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // Mode 0: data line holds while the clock is high.
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    // A selected bus always means the master reports busy.
    p_cs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // Released chip select stays high at least one more cycle.
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);

    // Waiting for write data parks the serial clock low.
    p_stall_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!spi_sclk && !spi_cs_n));

    // Received bytes only appear within a busy transaction.
    p_rx_in_xact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

endmodule

bind sram_spi_master sram_spi_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .busy     (busy),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid)
);

// File: tb/sram_model.sv
// Behavioural serial SRAM for the bench: mode-0 slave with a byte log,
// a 256-byte array indexed by the low address byte, and a mode register.
module sram_model #(
    parameter int ABYTES = 2
) (
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);
    logic [7:0]  mem [0:255];
    logic [7:0]  log_b [0:31];
    logic [7:0]  mode_reg;
    logic [7:0]  shin;
    logic [7:0]  outb;
    logic [7:0]  cmd;
    logic [23:0] addr;
    int nbytes;
    int xacts;
    int bitc;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mode_reg = 8'h00;
        nbytes = 0;
        xacts = 0;
        bitc = 0;
        outb = 8'h00;
        shin = 8'h00;
        cmd = 8'h00;
        addr = '0;
        miso = 1'b0;
    end

    always @(negedge cs_n) begin
        bitc = 0;
        nbytes = 0;
        xacts = xacts + 1;
        outb = 8'h00;
        miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            shin = {shin[6:0], mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                bitc = 0;
                if (nbytes < 32) log_b[nbytes] = shin;
                if (nbytes == 0) begin
                    cmd = shin;
                    addr = '0;
                    if (cmd == 8'h05) outb = mode_reg;
                end else if (cmd == 8'h03 || cmd == 8'h02) begin
                    if (nbytes <= ABYTES) begin
                        addr = {addr[15:0], shin};
                        if (nbytes == ABYTES && cmd == 8'h03) outb = mem[addr[7:0]];
                    end else begin
                        if (cmd == 8'h02) mem[addr[7:0]] = shin;
                        addr = addr + 24'd1;
                        if (cmd == 8'h03) outb = mem[addr[7:0]];
                    end
                end else if (cmd == 8'h01 && nbytes == 1) begin
                    mode_reg = shin;
                end
                nbytes = nbytes + 1;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) miso = outb[7 - bitc];
    end

endmodule

// File: tb/sram_spi_master_test.sv
// Directed bench: one task per scenario, each checking its own results.
module sram_spi_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_s = 1'b0;
    logic        req_valid_b = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        cur_big = 1'b0;

    logic s_tx_ready, s_rx_valid, s_busy, s_cs_n, s_sclk, s_mosi, s_miso;
    logic b_tx_ready, b_rx_valid, b_busy, b_cs_n, b_sclk, b_mosi, b_miso;
    logic [7:0] s_rx_data, b_rx_data;

    int nchecks = 0;
    int nerrs = 0;
    int hi_run = 0;
    int min_gap = 1000;
    int r6_viol = 0;
    logic [7:0] rxq[$];
    logic [7:0] wbuf [0:7];

    always #5 clk = ~clk;

    sram_spi_master #(.MEM_KBIT(256)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_s), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(s_tx_ready), .rx_valid(s_rx_valid),
        .rx_data(s_rx_data), .busy(s_busy), .spi_cs_n(s_cs_n),
        .spi_sclk(s_sclk), .spi_mosi(s_mosi), .spi_miso(s_miso));

    sram_spi_master #(.MEM_KBIT(1024)) uut_big (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(b_tx_ready), .rx_valid(b_rx_valid),
        .rx_data(b_rx_data), .busy(b_busy), .spi_cs_n(b_cs_n),
        .spi_sclk(b_sclk), .spi_mosi(b_mosi), .spi_miso(b_miso));

    sram_model #(.ABYTES(2)) m_s (.cs_n(s_cs_n), .sclk(s_sclk), .mosi(s_mosi), .miso(s_miso));
    sram_model #(.ABYTES(3)) m_b (.cs_n(b_cs_n), .sclk(b_sclk), .mosi(b_mosi), .miso(b_miso));

    wire busy_m  = cur_big ? b_busy : s_busy;
    wire ready_m = cur_big ? b_tx_ready : s_tx_ready;

    // Observers: received bytes, chip-select gap, idle-clock rule (R6).
    always @(negedge clk) begin
        if (s_rx_valid) rxq.push_back(s_rx_data);
        if (b_rx_valid) rxq.push_back(b_rx_data);
        if (rst_n) begin
            if (s_cs_n) hi_run++;
            else begin
                if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
            end
            if ((s_cs_n && s_sclk) || (b_cs_n && b_sclk)) r6_viol++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [23:0] a, input logic [15:0] n);
        @(negedge clk);
        while (busy_m) @(negedge clk);
        req_op = op; req_addr = a; req_len = n;
        if (cur_big) req_valid_b = 1'b1; else req_valid_s = 1'b1;
        @(negedge clk);
        req_valid_s = 1'b0; req_valid_b = 1'b0;
    endtask

    task automatic feed(input int n, input int stall);
        for (int i = 0; i < n; i++) begin
            while (!ready_m) @(negedge clk);
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                check(s_sclk == 1'b0 && s_cs_n == 1'b0, "R9 stall holds clock low, select low",
                      {s_sclk, s_cs_n}, 0);
            end
            tx_valid = 1'b1; tx_data = wbuf[i];
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_m) @(negedge clk);
    endtask

    task automatic t_reset();
        check(s_cs_n == 1'b1, "R11 cs_n after reset", s_cs_n, 1);
        check({s_sclk, s_busy, s_tx_ready, s_rx_valid} == 4'b0, "R11 idle outputs after reset",
              {s_sclk, s_busy, s_tx_ready, s_rx_valid}, 0);
    endtask

    task automatic t_write_burst();
        int x0;
        cur_big = 1'b0;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F; wbuf[3] = 8'hF0;
        x0 = m_s.xacts;
        issue(2'd1, 24'h000012, 16'd4);
        feed(4, 0);
        wait_idle();
        check(m_s.log_b[0] == 8'h02, "R2 write command byte", m_s.log_b[0], 8'h02);
        check(m_s.log_b[1] == 8'h00 && m_s.log_b[2] == 8'h12, "R3 two-byte address MSB first",
              {m_s.log_b[1], m_s.log_b[2]}, 16'h0012);
        check(m_s.nbytes == 7, "R2 write frame length", m_s.nbytes, 7);
        check(m_s.mem[8'h12] == 8'hA5 && m_s.mem[8'h15] == 8'hF0, "R2 written data",
              {m_s.mem[8'h12], m_s.mem[8'h15]}, 16'hA5F0);
        check(m_s.xacts == x0 + 1, "R4 one select per burst", m_s.xacts - x0, 1);
    endtask

    task automatic t_read_burst();
        cur_big = 1'b0;
        rxq.delete();
        issue(2'd0, 24'h000012, 16'd4);
        wait_idle();
        check(m_s.log_b[0] == 8'h03, "R1 read command byte", m_s.log_b[0], 8'h03);
        check(m_s.log_b[3] == 8'h00 && m_s.nbytes == 7, "R1 dummy bytes and frame length",
              m_s.nbytes, 7);
        check(rxq.size() == 4, "R1 received byte count", rxq.size(), 4);
        if (rxq.size() == 4) begin
            check({rxq[0], rxq[1], rxq[2], rxq[3]} == 32'hA53C0FF0, "R1 received bytes",
                  {rxq[0], rxq[1], rxq[2], rxq[3]}, 32'hA53C0FF0);
        end
    endtask

    task automatic t_write_stall();
        cur_big = 1'b0;
        wbuf[0] = 8'h81; wbuf[1] = 8'h7E;
        issue(2'd1, 24'h000040, 16'd2);
        feed(2, 40);
        wait_idle();
        check(m_s.mem[8'h40] == 8'h81 && m_s.mem[8'h41] == 8'h7E, "R9 data after stall",
              {m_s.mem[8'h40], m_s.mem[8'h41]}, 16'h817E);
    endtask

    task automatic t_mode();
        cur_big = 1'b0;
        wbuf[0] = 8'h40;
        issue(2'd3, 24'h0, 16'd5);
        feed(1, 0);
        wait_idle();
        check(m_s.log_b[0] == 8'h01 && m_s.nbytes == 2, "R5 mode write frame",
              {m_s.log_b[0], 8'(m_s.nbytes)}, 16'h0102);
        check(m_s.mode_reg == 8'h40, "R5 mode value written", m_s.mode_reg, 8'h40);
        rxq.delete();
        issue(2'd2, 24'h0, 16'd9);
        wait_idle();
        check(m_s.log_b[0] == 8'h05 && m_s.nbytes == 2, "R5 mode read frame",
              {m_s.log_b[0], 8'(m_s.nbytes)}, 16'h0502);
        check(rxq.size() == 1 && rxq[0] == 8'h40, "R5 mode read value",
              (rxq.size() > 0) ? rxq[0] : 0, 8'h40);
    endtask

    task automatic t_zero_len();
        cur_big = 1'b0;
        rxq.delete();
        issue(2'd0, 24'h000077, 16'd0);
        wait_idle();
        check(m_s.nbytes == 3 && rxq.size() == 0, "R10 zero-length read frame",
              m_s.nbytes, 3);
    endtask

    task automatic t_busy_ignore();
        int x0;
        cur_big = 1'b0;
        x0 = m_s.xacts;
        issue(2'd0, 24'h000012, 16'd2);
        check(s_busy == 1'b1, "R7 busy after accept", s_busy, 1);
        repeat (10) @(negedge clk);
        req_op = 2'd1; req_valid_s = 1'b1;
        @(negedge clk);
        req_valid_s = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(m_s.xacts == x0 + 1 && s_cs_n == 1'b1 && !s_busy, "R7 request while busy ignored",
              m_s.xacts - x0, 1);
    endtask

    task automatic t_b2b();
        cur_big = 1'b0;
        min_gap = 1000;
        issue(2'd0, 24'h000012, 16'd1);
        issue(2'd0, 24'h000013, 16'd1);
        wait_idle();
        check(min_gap >= 2 && min_gap < 1000, "R8 chip-select gap", min_gap, 2);
    endtask

    task automatic t_big();
        cur_big = 1'b1;
        wbuf[0] = 8'h5A;
        issue(2'd1, 24'h012345, 16'd1);
        feed(1, 0);
        wait_idle();
        check(m_b.nbytes == 5, "R3 three-byte address frame", m_b.nbytes, 5);
        check({m_b.log_b[1], m_b.log_b[2], m_b.log_b[3]} == 24'h012345, "R3 address order",
              {m_b.log_b[1], m_b.log_b[2], m_b.log_b[3]}, 24'h012345);
        rxq.delete();
        issue(2'd0, 24'h012345, 16'd1);
        wait_idle();
        check(rxq.size() == 1 && rxq[0] == 8'h5A, "R3 readback on large device",
              (rxq.size() > 0) ? rxq[0] : 0, 8'h5A);
        cur_big = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_burst();
        t_read_burst();
        t_write_stall();
        t_mode();
        t_zero_len();
        t_busy_ignore();
        t_b2b();
        t_big();
        check(r6_viol == 0, "R6 clock idle low outside select", r6_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        #1000000;
        nchecks++;
        nerrs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

endmodule